// File: doc/BRIEF.md
# Dual-Read Register File with Pair Access

This block is the working-register store of a small 8-bit processor core. It holds thirty-two 8-bit registers and serves two independent combinational byte read ports plus one 16-bit pair read port. In each cycle the core may write either a single byte or an aligned pair of registers. A pair write puts the low half of the result in the even register and the high half in the odd register above it. The six highest registers also act as three 16-bit address pointers, and these are presented continuously on dedicated outputs.

The same registers are visible to the load/store path through a byte-wide data-space port. Addresses below 32 select the register of the same number. Addresses at or above 32 belong to memory outside this block: a read there returns zero and a write there changes nothing. Any register, including the pointer registers, can be reached this way. When the core and the data-space port write the same register in the same cycle, the core's value is stored.

Writes land on the rising clock edge. Reads always show the contents from before that edge, with no forwarding of a write that is still pending.

Top module: `gpr_bank`

## Requirements
- R1: A synchronous reset, active high, clears all 32 registers to 0x00 at the clock edge on which it is sampled.
- R2: The ports `rd_a_data` and `rd_b_data` combinationally return the register selected by `rd_a_idx` and `rd_b_idx`, independently of each other.
- R3: When `core_we`=1 and `core_wide`=0, `core_wdata[7:0]` is written to register `core_widx` at the next rising edge. `core_wdata[15:8]` is ignored and no other register changes.
- R4: When `core_we`=1 and `core_wide`=1, with k = `core_widx[4:1]`, `core_wdata[7:0]` goes to register 2k and `core_wdata[15:8]` goes to register 2k+1 at the next edge. Bit 0 of `core_widx` is ignored.
- R5: `rd_wide_data` returns {R[2k+1], R[2k]} with k = `rd_wide_idx[4:1]`. Bit 0 of `rd_wide_idx` is ignored.
- R6: `ptr_x` = {R27, R26}, `ptr_y` = {R29, R28} and `ptr_z` = {R31, R30}, each valid in every cycle.
- R7: For `mem_addr` < 0x20, `mem_rdata` returns register number `mem_addr`.
- R8: For `mem_addr` < 0x20 with `mem_we`=1, `mem_wdata` is written to register number `mem_addr` at the next edge. This also holds in the same cycle as a core write to a different register.
- R9: For `mem_addr` >= 0x20, `mem_rdata` is 0x00 and a write with `mem_we`=1 changes no register, including when the low five address bits alone would match a register.
- R10: If a core write and a data-space write reach the same register in the same cycle, the core data is stored.
- R11: During a cycle in which a register is being written, all read ports still return its old value. The new value appears only after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 5 | Register number for read port A |
| rd_a_data | output | 8 | Read port A data |
| rd_b_idx | input | 5 | Register number for read port B |
| rd_b_data | output | 8 | Read port B data |
| rd_wide_idx | input | 5 | Pair read selector (bit 0 ignored) |
| rd_wide_data | output | 16 | Pair read data, odd register in the high byte |
| core_we | input | 1 | Core write enable |
| core_wide | input | 1 | 1 = pair write, 0 = byte write |
| core_widx | input | 5 | Core write register number |
| core_wdata | input | 16 | Core write data (low byte only for byte writes) |
| ptr_x | output | 16 | Pointer view of registers 27:26 |
| ptr_y | output | 16 | Pointer view of registers 29:28 |
| ptr_z | output | 16 | Pointer view of registers 31:30 |
| mem_addr | input | 16 | Data-space byte address |
| mem_we | input | 1 | Data-space write enable |
| mem_wdata | input | 8 | Data-space write data |
| mem_rdata | output | 8 | Data-space read data |

## Verification
The assertions check in every cycle that a byte write or pair write lands in the addressed registers on the following edge, and that a colliding data-space write loses to the core. They also check that an out-of-range data-space write leaves the file untouched, that reset clears it, and that the data-space read and pointer outputs agree with the operand read ports. The absence of write-through forwarding, the low-bit aliasing of out-of-range addresses, and the contents of every register after a mixed sequence of writes are shown only by the bench scenarios, which compare each register against an independent model.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    parameter int unsigned GPR_COUNT  = 32;
    parameter int unsigned GPR_WIDTH  = 8;
    parameter int unsigned DSPACE_AW  = 16;
    parameter int unsigned PTR_COUNT  = 3;

    // selector for the kind of core write
    typedef enum logic {
        WR_BYTE = 1'b0,
        WR_PAIR = 1'b1
    } wr_kind_e;
endpackage

// File: rtl/gpr_read_mux.sv
module gpr_read_mux #(
    parameter int unsigned NREG = gpr_pkg::GPR_COUNT,
    parameter int unsigned DW   = gpr_pkg::GPR_WIDTH,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic [NREG-1:0][DW-1:0] regs_i,
    input  logic [IW-1:0]           idx_i,
    output logic [DW-1:0]           data_o
);
    always_comb begin
        data_o = '0;
        if (int'(idx_i) < int'(NREG)) begin
            data_o = regs_i[idx_i];
        end
    end
endmodule

// File: rtl/gpr_write_ctrl.sv
module gpr_write_ctrl #(
    parameter int unsigned NREG = gpr_pkg::GPR_COUNT,
    parameter int unsigned DW   = gpr_pkg::GPR_WIDTH,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     core_we_i,
    input  gpr_pkg::wr_kind_e        core_kind_i,
    input  logic [IW-1:0]            core_idx_i,
    input  logic [2*DW-1:0]          core_data_i,
    input  logic                     ds_we_i,
    input  logic [IW-1:0]            ds_idx_i,
    input  logic [DW-1:0]            ds_data_i,
    output logic [NREG-1:0]          we_o,
    output logic [NREG-1:0][DW-1:0]  wd_o
);
    logic [NREG-1:0] core_hit;
    logic [NREG-1:0] ds_hit;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        localparam logic [IW-1:0] RI = IW'(r);
        logic          pair_match;
        logic          byte_match;
        logic [DW-1:0] core_val;

        assign pair_match  = (core_idx_i[IW-1:1] == RI[IW-1:1]);
        assign byte_match  = (core_idx_i == RI);
        assign core_hit[r] = core_we_i &&
                             ((core_kind_i == gpr_pkg::WR_PAIR) ? pair_match : byte_match);
        assign core_val    = ((core_kind_i == gpr_pkg::WR_PAIR) && RI[0])
                             ? core_data_i[2*DW-1:DW] : core_data_i[DW-1:0];
        assign ds_hit[r]   = ds_we_i && (ds_idx_i == RI);
        // core write takes priority over the data-space write
        assign we_o[r]     = core_hit[r] || ds_hit[r];
        assign wd_o[r]     = core_hit[r] ? core_val : ds_data_i;
    end

    // R4
    pair_two_hits_chk: assert property (@(posedge clk) disable iff (rst)
        (core_we_i && core_kind_i == gpr_pkg::WR_PAIR) |-> $countones(core_hit) == 2);

    // R3
    byte_one_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (core_we_i && core_kind_i == gpr_pkg::WR_BYTE) |-> $countones(core_hit) == 1);

    // R8
    ds_single_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ds_hit));
endmodule

// File: rtl/gpr_dspace.sv
module gpr_dspace #(
    parameter int unsigned NREG = gpr_pkg::GPR_COUNT,
    parameter int unsigned DW   = gpr_pkg::GPR_WIDTH,
    parameter int unsigned MAW  = gpr_pkg::DSPACE_AW,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic [NREG-1:0][DW-1:0] regs_i,
    input  logic [MAW-1:0]          addr_i,
    input  logic                    we_i,
    input  logic [DW-1:0]           wdata_i,
    output logic                    ds_we_o,
    output logic [IW-1:0]           ds_idx_o,
    output logic [DW-1:0]           ds_wdata_o,
    output logic [DW-1:0]           rdata_o
);
    logic          in_range;
    logic [DW-1:0] hit_data;

    assign in_range   = (addr_i < MAW'(NREG));
    assign ds_idx_o   = addr_i[IW-1:0];
    assign ds_we_o    = we_i && in_range;
    assign ds_wdata_o = wdata_i;

    gpr_read_mux #(.NREG(NREG), .DW(DW)) u_ds_mux (
        .regs_i (regs_i),
        .idx_i  (ds_idx_o),
        .data_o (hit_data)
    );

    assign rdata_o = in_range ? hit_data : '0;
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
    parameter int unsigned NREG = gpr_pkg::GPR_COUNT,
    parameter int unsigned DW   = gpr_pkg::GPR_WIDTH,
    parameter int unsigned MAW  = gpr_pkg::DSPACE_AW,
    localparam int unsigned IW  = $clog2(NREG),
    localparam int unsigned PW  = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] rd_a_idx,
    output logic [DW-1:0] rd_a_data,
    input  logic [IW-1:0] rd_b_idx,
    output logic [DW-1:0] rd_b_data,
    input  logic [IW-1:0] rd_wide_idx,
    output logic [PW-1:0] rd_wide_data,
    input  logic          core_we,
    input  logic          core_wide,
    input  logic [IW-1:0] core_widx,
    input  logic [PW-1:0] core_wdata,
    output logic [PW-1:0] ptr_x,
    output logic [PW-1:0] ptr_y,
    output logic [PW-1:0] ptr_z,
    input  logic [MAW-1:0] mem_addr,
    input  logic          mem_we,
    input  logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] mem_rdata
);
    localparam int unsigned NPTR     = gpr_pkg::PTR_COUNT;
    localparam int unsigned PTR_BASE = NREG - 2 * NPTR;
    localparam int unsigned NRD      = 2;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
    } state_t;

    state_t st_d, st_q;

    logic [NREG-1:0]          we_vec;
    logic [NREG-1:0][DW-1:0]  wd_vec;
    logic                     ds_we;
    logic [IW-1:0]            ds_idx;
    logic [DW-1:0]            ds_wdata;
    gpr_pkg::wr_kind_e        core_kind;

    assign core_kind = core_wide ? gpr_pkg::WR_PAIR : gpr_pkg::WR_BYTE;

    // ---------------- byte read ports ----------------
    logic [NRD-1:0][IW-1:0] rd_idx;
    logic [NRD-1:0][DW-1:0] rd_data;
    assign rd_idx[0] = rd_a_idx;
    assign rd_idx[1] = rd_b_idx;

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        gpr_read_mux #(.NREG(NREG), .DW(DW)) u_mux (
            .regs_i (st_q.regs),
            .idx_i  (rd_idx[p]),
            .data_o (rd_data[p])
        );
    end
    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];

    // ---------------- pair read port ----------------
    logic [DW-1:0] wide_lo, wide_hi;
    gpr_read_mux #(.NREG(NREG), .DW(DW)) u_wide_lo (
        .regs_i (st_q.regs),
        .idx_i  ({rd_wide_idx[IW-1:1], 1'b0}),
        .data_o (wide_lo)
    );
    gpr_read_mux #(.NREG(NREG), .DW(DW)) u_wide_hi (
        .regs_i (st_q.regs),
        .idx_i  ({rd_wide_idx[IW-1:1], 1'b1}),
        .data_o (wide_hi)
    );
    assign rd_wide_data = {wide_hi, wide_lo};

    // ---------------- pointer views ----------------
    logic [NPTR-1:0][PW-1:0] ptr_view;
    for (genvar k = 0; k < NPTR; k++) begin : g_ptr
        assign ptr_view[k] = {st_q.regs[PTR_BASE + 2*k + 1], st_q.regs[PTR_BASE + 2*k]};
    end
    assign ptr_x = ptr_view[0];
    assign ptr_y = ptr_view[1];
    assign ptr_z = ptr_view[2];

    // ---------------- data-space port ----------------
    gpr_dspace #(.NREG(NREG), .DW(DW), .MAW(MAW)) u_dspace (
        .regs_i     (st_q.regs),
        .addr_i     (mem_addr),
        .we_i       (mem_we),
        .wdata_i    (mem_wdata),
        .ds_we_o    (ds_we),
        .ds_idx_o   (ds_idx),
        .ds_wdata_o (ds_wdata),
        .rdata_o    (mem_rdata)
    );

    // ---------------- write arbitration ----------------
    gpr_write_ctrl #(.NREG(NREG), .DW(DW)) u_wctrl (
        .clk         (clk),
        .rst         (rst),
        .core_we_i   (core_we),
        .core_kind_i (core_kind),
        .core_idx_i  (core_widx),
        .core_data_i (core_wdata),
        .ds_we_i     (ds_we),
        .ds_idx_i    (ds_idx),
        .ds_data_i   (ds_wdata),
        .we_o        (we_vec),
        .wd_o        (wd_vec)
    );

    // ---------------- state update ----------------
    always_comb begin
        st_d = st_q;
        for (int r = 0; r < int'(NREG); r++) begin
            if (we_vec[r]) begin
                st_d.regs[r] = wd_vec[r];
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // ---------------- assertions ----------------
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (st_q == '0));

    // R3
    byte_write_chk: assert property (@(posedge clk) disable iff (rst)
        (core_we && !core_wide) |=>
            (st_q.regs[$past(core_widx)] == $past(core_wdata[DW-1:0])));

    // R4
    pair_write_chk: assert property (@(posedge clk) disable iff (rst)
        (core_we && core_wide) |=>
            ((st_q.regs[{$past(core_widx[IW-1:1]), 1'b0}] == $past(core_wdata[DW-1:0])) &&
             (st_q.regs[{$past(core_widx[IW-1:1]), 1'b1}] == $past(core_wdata[PW-1:DW]))));

    // R10
    core_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (core_we && !core_wide && mem_we && (mem_addr == MAW'(core_widx))) |=>
            (st_q.regs[$past(core_widx)] == $past(core_wdata[DW-1:0])));

    // R9
    oob_write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !core_we && (mem_addr >= MAW'(NREG))) |=> (st_q == $past(st_q)));

    // R7
    ds_read_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_addr == MAW'(rd_a_idx)) |-> (mem_rdata == rd_a_data));

    // R6
    ptr_z_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_wide_idx[IW-1:1] == (IW-1)'((NREG - 2) / 2)) |-> (ptr_z == rd_wide_data));
endmodule

// File: tb/tb_gpr_bank.sv
`timescale 1ns/1ps
module tb_gpr_bank;
    localparam int NREG = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, rd_wide_idx = '0, core_widx = '0;
    logic [7:0]  rd_a_data, rd_b_data, mem_wdata = '0, mem_rdata;
    logic [15:0] rd_wide_data, core_wdata = '0, ptr_x, ptr_y, ptr_z, mem_addr = '0;
    logic        core_we = 1'b0, core_wide = 1'b0, mem_we = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [7:0] model [NREG];

    always #10 clk = ~clk;

    gpr_bank dut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .rd_wide_idx(rd_wide_idx), .rd_wide_data(rd_wide_data),
        .core_we(core_we), .core_wide(core_wide), .core_widx(core_widx), .core_wdata(core_wdata),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    typedef struct packed {
        logic [1:0]  op;    // 0 core byte, 1 core pair, 2 data-space write, 3 data-space out of range
        logic [15:0] idx;
        logic [15:0] data;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{2'd0, 16'd5,     16'h00A5},
        '{2'd1, 16'd26,    16'h1234},
        '{2'd1, 16'd29,    16'hBEEF},
        '{2'd2, 16'h001F,  16'h0077},
        '{2'd3, 16'h0025,  16'h0099},
        '{2'd0, 16'd0,     16'h0F3C},
        '{2'd1, 16'd31,    16'hC0DE},
        '{2'd3, 16'h0120,  16'h0044}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        core_we = 0; core_wide = 0; core_widx = '0; core_wdata = '0;
        mem_we = 0; mem_addr = '0; mem_wdata = '0;
    endtask

    task automatic check_all(input string req);
        for (int r = 0; r < NREG; r++) begin
            rd_a_idx = 5'(r);
            rd_b_idx = 5'(NREG - 1 - r);
            #1;
            chk(req, {8'h00, rd_a_data}, {8'h00, model[r]});
            chk(req, {8'h00, rd_b_data}, {8'h00, model[NREG - 1 - r]});
        end
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog R1..all actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NREG; r++) model[r] = 8'h00;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state through the data-space port (R7)
        for (int r = 0; r < NREG; r++) begin
            mem_addr = 16'(r);
            #1;
            chk("R1", {8'h00, mem_rdata}, 16'h0000);
        end

        // table walk: R2 R3 R4 R8 R9
        for (int v = 0; v < 8; v++) begin
            string req;
            @(negedge clk);
            idle();
            case (VEC[v].op)
                2'd0: begin core_we = 1; core_widx = VEC[v].idx[4:0]; core_wdata = VEC[v].data; req = "R3"; end
                2'd1: begin core_we = 1; core_wide = 1; core_widx = VEC[v].idx[4:0]; core_wdata = VEC[v].data; req = "R4"; end
                2'd2: begin mem_we = 1; mem_addr = VEC[v].idx; mem_wdata = VEC[v].data[7:0]; req = "R8"; end
                default: begin mem_we = 1; mem_addr = VEC[v].idx; mem_wdata = VEC[v].data[7:0]; req = "R9"; end
            endcase
            @(posedge clk);
            #1;
            idle();
            case (VEC[v].op)
                2'd0: model[VEC[v].idx[4:0]] = VEC[v].data[7:0];
                2'd1: begin
                    model[{VEC[v].idx[4:1], 1'b0}] = VEC[v].data[7:0];
                    model[{VEC[v].idx[4:1], 1'b1}] = VEC[v].data[15:8];
                end
                2'd2: if (VEC[v].idx < 16'd32) model[VEC[v].idx[4:0]] = VEC[v].data[7:0];
                default: ;
            endcase
            check_all(req);
        end

        // R5 pair read, bit 0 ignored
        rd_wide_idx = 5'd26; #1; chk("R5", rd_wide_data, {model[27], model[26]});
        rd_wide_idx = 5'd29; #1; chk("R5", rd_wide_data, {model[29], model[28]});
        rd_wide_idx = 5'd5;  #1; chk("R5", rd_wide_data, {model[5], model[4]});

        // R6 pointer views
        chk("R6", ptr_x, {model[27], model[26]});
        chk("R6", ptr_y, {model[29], model[28]});
        chk("R6", ptr_z, {model[31], model[30]});

        // R7 data-space reads
        mem_addr = 16'h0005; #1; chk("R7", {8'h00, mem_rdata}, {8'h00, model[5]});
        mem_addr = 16'h001A; #1; chk("R7", {8'h00, mem_rdata}, {8'h00, model[26]});
        // R9 out-of-range reads, including low-bit alias of R0/R5
        mem_addr = 16'h0025; #1; chk("R9", {8'h00, mem_rdata}, 16'h0000);
        mem_addr = 16'h0120; #1; chk("R9", {8'h00, mem_rdata}, 16'h0000);

        // R11 no bypass: old value visible before the edge
        @(negedge clk);
        idle();
        core_we = 1; core_widx = 5'd7; core_wdata = 16'h005A;
        rd_a_idx = 5'd7; rd_b_idx = 5'd7; rd_wide_idx = 5'd6; mem_addr = 16'd7;
        #1;
        chk("R11", {8'h00, rd_a_data}, {8'h00, model[7]});
        chk("R11", {8'h00, rd_b_data}, {8'h00, model[7]});
        chk("R11", rd_wide_data, {model[7], model[6]});
        chk("R11", {8'h00, mem_rdata}, {8'h00, model[7]});
        @(posedge clk); #1;
        idle();
        model[7] = 8'h5A;
        rd_a_idx = 5'd7; #1;
        chk("R11", {8'h00, rd_a_data}, 16'h005A);

        // R10 byte conflict: core wins
        @(negedge clk);
        core_we = 1; core_widx = 5'd9; core_wdata = 16'h0011;
        mem_we = 1; mem_addr = 16'd9; mem_wdata = 8'h22;
        @(posedge clk); #1; idle();
        model[9] = 8'h11;
        rd_a_idx = 5'd9; #1; chk("R10", {8'h00, rd_a_data}, 16'h0011);

        // R10 pair conflict on the high byte
        @(negedge clk);
        core_we = 1; core_wide = 1; core_widx = 5'd10; core_wdata = 16'hAB01;
        mem_we = 1; mem_addr = 16'd11; mem_wdata = 8'h66;
        @(posedge clk); #1; idle();
        model[10] = 8'h01; model[11] = 8'hAB;
        rd_a_idx = 5'd11; rd_b_idx = 5'd10; #1;
        chk("R10", {8'h00, rd_a_data}, 16'h00AB);
        chk("R10", {8'h00, rd_b_data}, 16'h0001);

        // R8 simultaneous writes to distinct registers both land
        @(negedge clk);
        core_we = 1; core_widx = 5'd13; core_wdata = 16'h0033;
        mem_we = 1; mem_addr = 16'd12; mem_wdata = 8'h44;
        @(posedge clk); #1; idle();
        model[13] = 8'h33; model[12] = 8'h44;
        check_all("R8");

        // R1 reset mid-run
        @(negedge clk);
        rst = 1;
        @(posedge clk); #1;
        rst = 0;
        for (int r = 0; r < NREG; r++) model[r] = 8'h00;
        check_all("R1");
        chk("R1", ptr_z, 16'h0000);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule